// File: doc/BRIEF.md
# Instruction Issue and Skip Sequencer

This block is the issue stage of a small processor whose instructions are 24-bit words. It owns the program counter, drives a fetch address, takes instruction words over a valid/ready fetch port, and each instruction cycle hands the execute stage either a real word or a NOP bubble over a valid/ready issue port. The top 8 bits of each word are the opcode. The block puts that opcode on a lookup output. A small class table outside the block answers, in the same cycle, whether the instruction is two words long, whether it is a conditional skip, whether it can change the flow, and how many extra cycles it costs.

The execute side returns the outcome of a skip or flow instruction on two plain pins, `fb_taken` and `fb_target`. These are sampled in the cycle in which the first word of that instruction is accepted on the issue port. The block spends cycles as the class requires:
- A taken flow change adds one flush bubble and reloads the PC.
- Extra-cycle instructions add bubbles.
- A taken skip consumes the following instruction, with one bubble per word skipped.
- A stray extension word, whose opcode is zero, goes out as a one-cycle NOP.

Back-pressure rules:
- Issue port: a transfer happens when `iss_valid` and `iss_ready` are both high. While `iss_valid` is high and `iss_ready` is low, the block holds the issue outputs and the fetch address unchanged.
- Fetch port: the fetch side, once it raises `fetch_valid` for an address, must hold the word and `fetch_valid` until `fetch_ready` accepts it.
- Bubble cycles: bubbles that do not stand for a skipped word consume no fetch word.

Top module: `iss_seq_top`

## Requirements
- R1: After reset the fetch address equals the parameter RESET_PC and no issue transfer is offered while `fetch_valid` is low.
- R2: An ordinary one-word instruction (opcode non-zero, no class bits, extra count zero) is issued once with `iss_bubble`=0, and the fetch address then advances by one.
- R3: A word whose top 8 bits are zero, met at an instruction boundary, is issued for exactly one cycle with `iss_bubble`=1, whatever the class inputs report for it.
- R4: A two-word instruction is issued as two consecutive non-bubble transfers carrying the first and then the second word, and the fetch address advances by two.
- R5: An instruction with extra count N is followed by N bubble transfers (word all zero, `iss_bubble`=1) that consume no fetch word.
- R6: A flow instruction with `fb_taken`=1 is followed by one flush bubble plus its extra bubbles, and the next fetch address is `fb_target`; for a two-word flow instruction the reload happens after the second word. With `fb_taken`=0 no flush bubble is added and the PC steps normally.
- R7: A skip instruction with `fb_taken`=1, and without the flow bit, consumes the next instruction as bubbles: one bubble if that instruction is one word long, two if it is two words long. Its extra bubbles come first.
- R8: While `iss_valid`=1 and `iss_ready`=0, `iss_valid`, `iss_word` and `iss_bubble` keep their values into the next cycle. The fetch address changes only on a fetch handshake.
- R9: Every bubble transfer carries an opcode field of zero.
- R10: When the next transfer needs a fetch word and `fetch_valid` is low, `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | output | PC_W | Program counter, word address of the word wanted |
| fetch_word | input | WORD_W | Instruction word at `fetch_addr` |
| fetch_valid | input | 1 | `fetch_word` is present |
| fetch_ready | output | 1 | The word is consumed this cycle |
| cls_opcode | output | OPC_W | Opcode of `fetch_word` for the class table |
| cls_two_word | input | 1 | Opcode is a two-word instruction |
| cls_skip | input | 1 | Opcode is a conditional skip |
| cls_flow | input | 1 | Opcode may change the PC |
| cls_extra | input | XTRA_W | Extra cycles the opcode needs |
| fb_taken | input | 1 | Skip or flow outcome, sampled on first-word issue |
| fb_target | input | PC_W | New PC for a taken flow change |
| iss_valid | output | 1 | An issue transfer is offered |
| iss_ready | input | 1 | Execute accepts the transfer |
| iss_word | output | WORD_W | Issued word (zero for inserted bubbles) |
| iss_bubble | output | 1 | The transfer executes as a NOP |

## Verification
The bench builds the block with PC_W=16, XTRA_W=2 and a non-zero RESET_PC of 4. This makes reset-value errors visible, and it allows up to three extra cycles plus a flush, so one instruction can be followed by four back-to-back bubbles. The program is 64 words and wraps, with computed branch targets that often land on extension words. This reaches stray-NOP issue, skips over two-word and over zero-opcode words, and two-word taken flow instructions. Stalls on both ports are introduced in a second phase to exercise the hold rules in every state.

// File: rtl/iss_pkg.sv
package iss_pkg;
  typedef enum logic [2:0] {
    ST_WORD  = 3'd0,
    ST_EXT   = 3'd1,
    ST_BUB   = 3'd2,
    ST_SKIP1 = 3'd3,
    ST_SKIP2 = 3'd4
  } iss_state_e;
endpackage

// File: rtl/iss_class_dec.sv
module iss_class_dec #(
  parameter int OPC_W  = 8,
  parameter int XTRA_W = 2
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic              raw_two,
  input  logic              raw_skip,
  input  logic              raw_flow,
  input  logic [XTRA_W-1:0] raw_extra,
  output logic              is_nop,
  output logic              two,
  output logic              skip,
  output logic              flow,
  output logic [XTRA_W-1:0] extra
);
  // A zero opcode is an orphan extension word: plain NOP, table ignored (R3)
  always_comb begin
    is_nop = (opcode == '0);
    two    = raw_two  & ~is_nop;
    skip   = raw_skip & ~is_nop;
    flow   = raw_flow & ~is_nop;
    extra  = is_nop ? '0 : raw_extra;
  end
endmodule

// File: rtl/iss_pc_reg.sv
module iss_pc_reg #(
  parameter int          PC_W     = 16,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            load,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= PC_W'(RESET_PC);
    else if (load) pc <= target;
    else if (adv)  pc <= pc + 1'b1;
  end

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load |=> pc == $past(pc) + 1'b1);

  assert_pc_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pc == $past(target));
endmodule

// File: rtl/iss_ctrl.sv
module iss_ctrl
  import iss_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int XTRA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic              iss_ready,
  input  logic              is_nop,
  input  logic              two,
  input  logic              skip,
  input  logic              flow,
  input  logic [XTRA_W-1:0] extra,
  input  logic              fb_taken,
  input  logic [PC_W-1:0]   fb_target,
  output logic              iss_valid,
  output logic              iss_bubble,
  output logic              pass_word,
  output logic              fetch_ready,
  output logic              pc_adv,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_target
);
  localparam int CNT_W = XTRA_W + 1;

  iss_state_e       state, state_n;
  logic [CNT_W-1:0] bub_cnt, bub_cnt_n;
  logic             skip_pend, skip_pend_n;
  logic             load_pend, load_pend_n;
  logic [PC_W-1:0]  tgt_q, tgt_q_n;
  logic             fire, flow_tk, skip_tk;
  logic [CNT_W-1:0] cnt_new;

  always_comb begin
    iss_valid   = 1'b0;
    iss_bubble  = 1'b1;
    pass_word   = 1'b0;
    fetch_ready = 1'b0;
    unique case (state)
      ST_WORD: begin
        iss_valid   = fetch_valid;
        iss_bubble  = is_nop;
        pass_word   = 1'b1;
        fetch_ready = iss_ready;
      end
      ST_EXT: begin
        iss_valid   = fetch_valid;
        iss_bubble  = 1'b0;
        pass_word   = 1'b1;
        fetch_ready = iss_ready;
      end
      ST_BUB: iss_valid = 1'b1;
      ST_SKIP1, ST_SKIP2: begin
        iss_valid   = fetch_valid;
        fetch_ready = iss_ready;
      end
      default: iss_valid = 1'b0;
    endcase
  end

  assign fire    = iss_valid & iss_ready;
  assign flow_tk = flow & fb_taken;
  assign skip_tk = skip & fb_taken & ~flow;
  assign cnt_new = CNT_W'(extra) + CNT_W'(flow_tk);

  always_comb begin
    state_n     = state;
    bub_cnt_n   = bub_cnt;
    skip_pend_n = skip_pend;
    load_pend_n = load_pend;
    tgt_q_n     = tgt_q;
    pc_adv      = 1'b0;
    pc_load     = 1'b0;
    pc_target   = fb_target;
    if (fire) begin
      unique case (state)
        ST_WORD: begin
          pc_adv = 1'b1;
          if (!is_nop) begin
            bub_cnt_n   = cnt_new;
            skip_pend_n = skip_tk;
            if (two) begin
              load_pend_n = flow_tk;
              tgt_q_n     = fb_target;
              state_n     = ST_EXT;
            end else begin
              pc_load = flow_tk;
              if (cnt_new != '0)  state_n = ST_BUB;
              else if (skip_tk)   state_n = ST_SKIP1;
            end
          end
        end
        ST_EXT: begin
          pc_adv      = 1'b1;
          pc_load     = load_pend;
          pc_target   = tgt_q;
          load_pend_n = 1'b0;
          if (bub_cnt != '0)  state_n = ST_BUB;
          else if (skip_pend) state_n = ST_SKIP1;
          else                state_n = ST_WORD;
        end
        ST_BUB: begin
          bub_cnt_n = bub_cnt - 1'b1;
          if (bub_cnt == CNT_W'(1)) state_n = skip_pend ? ST_SKIP1 : ST_WORD;
        end
        ST_SKIP1: begin
          pc_adv      = 1'b1;
          skip_pend_n = 1'b0;
          state_n     = two ? ST_SKIP2 : ST_WORD;
        end
        ST_SKIP2: begin
          pc_adv  = 1'b1;
          state_n = ST_WORD;
        end
        default: state_n = ST_WORD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WORD;
      bub_cnt   <= '0;
      skip_pend <= 1'b0;
      load_pend <= 1'b0;
      tgt_q     <= '0;
    end else begin
      state     <= state_n;
      bub_cnt   <= bub_cnt_n;
      skip_pend <= skip_pend_n;
      load_pend <= load_pend_n;
      tgt_q     <= tgt_q_n;
    end
  end

  assert_nop_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WORD && fire && is_nop |=> state == ST_WORD);

  assert_bub_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_BUB && fire && bub_cnt != CNT_W'(1) |=> state == ST_BUB);
endmodule

// File: rtl/iss_seq_top.sv
module iss_seq_top #(
  parameter int          WORD_W   = 24,
  parameter int          OPC_W    = 8,
  parameter int          PC_W     = 16,
  parameter int          XTRA_W   = 2,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   fetch_addr,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  output logic [OPC_W-1:0]  cls_opcode,
  input  logic              cls_two_word,
  input  logic              cls_skip,
  input  logic              cls_flow,
  input  logic [XTRA_W-1:0] cls_extra,
  input  logic              fb_taken,
  input  logic [PC_W-1:0]   fb_target,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [WORD_W-1:0] iss_word,
  output logic              iss_bubble
);
  localparam int OPC_LSB = WORD_W - OPC_W;

  logic              is_nop, two, skip, flow, pass_word, pc_adv, pc_load;
  logic [XTRA_W-1:0] extra;
  logic [PC_W-1:0]   pc_target;

  assign cls_opcode = fetch_word[WORD_W-1:OPC_LSB];
  assign iss_word   = pass_word ? fetch_word : '0;

  iss_class_dec #(.OPC_W(OPC_W), .XTRA_W(XTRA_W)) dec_i (
    .opcode(cls_opcode), .raw_two(cls_two_word), .raw_skip(cls_skip),
    .raw_flow(cls_flow), .raw_extra(cls_extra), .is_nop(is_nop),
    .two(two), .skip(skip), .flow(flow), .extra(extra)
  );

  iss_ctrl #(.PC_W(PC_W), .XTRA_W(XTRA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .iss_ready(iss_ready),
    .is_nop(is_nop), .two(two), .skip(skip), .flow(flow), .extra(extra),
    .fb_taken(fb_taken), .fb_target(fb_target), .iss_valid(iss_valid),
    .iss_bubble(iss_bubble), .pass_word(pass_word), .fetch_ready(fetch_ready),
    .pc_adv(pc_adv), .pc_load(pc_load), .pc_target(pc_target)
  );

  iss_pc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) pc_i (
    .clk(clk), .rst_n(rst_n), .adv(pc_adv), .load(pc_load),
    .target(pc_target), .pc(fetch_addr)
  );

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_word) && $stable(iss_bubble));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && fetch_ready) |=> $stable(fetch_addr));

  assert_bubble_opc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_bubble |-> iss_word[WORD_W-1:OPC_LSB] == '0);
endmodule

// File: tb/iss_seq_top_tb.sv
module iss_seq_top_tb_top;
  localparam logic [15:0] RST_PC = 16'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] fetch_addr;
  logic [23:0] fetch_word;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [7:0]  cls_opcode;
  logic        cls_two_word, cls_skip, cls_flow;
  logic [1:0]  cls_extra;
  logic        fb_taken;
  logic [15:0] fb_target;
  logic        iss_valid;
  logic        iss_ready = 1'b0;
  logic [23:0] iss_word;
  logic        iss_bubble;

  logic [23:0] mem [0:63];
  int errors = 0, checks = 0, fires = 0, cycles = 0;
  bit done = 0, fetched = 0;

  always #5 clk = ~clk;

  // class table: {two, skip, flow, extra}; 0x00 deliberately claims two-word
  function automatic logic [4:0] cls_of(logic [7:0] op);
    case (op)
      8'h00: return 5'b10000;
      8'h20: return 5'b10000;
      8'h30: return 5'b00001;
      8'h31: return 5'b00010;
      8'h32: return 5'b00011;
      8'h40: return 5'b00100;
      8'h41: return 5'b00101;
      8'h50: return 5'b01000;
      8'h60: return 5'b10100;
      8'h70: return 5'b01001;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic [7:0] pick(int k);
    case (k % 13)
      0: return 8'h10;  1: return 8'h50;  2: return 8'h20;  3: return 8'h40;
      4: return 8'h60;  5: return 8'h30;  6: return 8'h70;  7: return 8'h00;
      8: return 8'h41;  9: return 8'h50;  10: return 8'h31; 11: return 8'h32;
      default: return 8'h10;
    endcase
  endfunction

  function automatic bit taken_fn(logic [15:0] a);
    return (a % 3) != 1;
  endfunction

  function automatic logic [15:0] tgt_fn(logic [15:0] a);
    return 16'((int'(a[5:0]) * 13 + 5) % 64);
  endfunction

  assign {cls_two_word, cls_skip, cls_flow, cls_extra} = cls_of(cls_opcode);
  assign fetch_word = mem[fetch_addr[5:0]];
  assign fb_taken   = taken_fn(fetch_addr);
  assign fb_target  = tgt_fn(fetch_addr);

  iss_seq_top #(.PC_W(16), .XTRA_W(2), .RESET_PC(RST_PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_word(fetch_word),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .cls_opcode(cls_opcode),
    .cls_two_word(cls_two_word), .cls_skip(cls_skip), .cls_flow(cls_flow),
    .cls_extra(cls_extra), .fb_taken(fb_taken), .fb_target(fb_target),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_word(iss_word),
    .iss_bubble(iss_bubble)
  );

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model: queue of expected transfers
  logic [23:0] q_word [$];
  bit          q_bub  [$];
  bit          q_nf   [$];
  logic [15:0] q_addr [$];
  string       q_tag  [$];
  logic [15:0] m_pc;

  task automatic push(logic [23:0] w, bit b, bit nf, logic [15:0] a, string t);
    q_word.push_back(w); q_bub.push_back(b); q_nf.push_back(nf);
    q_addr.push_back(a); q_tag.push_back(t);
  endtask

  task automatic expand();
    logic [23:0] w = mem[m_pc[5:0]];
    logic [4:0]  c = cls_of(w[23:16]);
    logic [15:0] q = m_pc + 16'd1;
    bit tk = taken_fn(m_pc), ftk, stk;
    int nb;
    if (w[23:16] == 8'h00) begin
      push(w, 1'b1, 1'b1, m_pc, "R3");  // stray extension word -> NOP
      m_pc = q;
      return;
    end
    ftk = c[2] && tk;
    stk = c[3] && tk && !c[2];
    push(w, 1'b0, 1'b1, m_pc, (c[4:2] == 3'b0 && c[1:0] == 2'b0) ? "R2" : "R4");
    if (c[4]) begin
      push(mem[q[5:0]], 1'b0, 1'b1, q, "R4");
      q = q + 16'd1;
    end
    if (ftk) q = tgt_fn(m_pc);
    nb = int'(c[1:0]) + (ftk ? 1 : 0);
    for (int i = 0; i < nb; i++) push(24'h0, 1'b1, 1'b0, 16'h0, ftk ? "R6" : "R5");
    if (stk) begin
      logic [23:0] s = mem[q[5:0]];
      bit two2 = (s[23:16] != 8'h00) && cls_of(s[23:16])[4];
      push(24'h0, 1'b1, 1'b1, q, "R7");
      q = q + 16'd1;
      if (two2) begin
        push(24'h0, 1'b1, 1'b1, q, "R7");
        q = q + 16'd1;
      end
    end
    m_pc = q;
  endtask

  // program image
  initial begin
    int i = 0, k = 0;
    while (i < 64) begin
      logic [7:0] op = pick(k);
      if (i == 63 && cls_of(op)[4]) op = 8'h10;
      mem[i] = {op, 16'(i * 257)};
      if (op != 8'h00 && cls_of(op)[4]) begin
        mem[i+1] = {8'h00, 16'(16'hA000 + i)};
        i += 2;
      end else i += 1;
      k++;
    end
  end

  // input driver
  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (cycles < 300) begin
        iss_ready   = 1'b1;
        fetch_valid = 1'b1;
      end else begin
        iss_ready = lf[0] | lf[3];
        if (!(fetch_valid && !fetched)) fetch_valid = lf[5] | lf[7];
      end
    end
  end

  // per-cycle comparison
  initial begin
    bit          prev_stall = 0;
    logic [23:0] prev_word = '0;
    bit          prev_bub = 0;
    @(negedge clk);
    // R1: reset state
    check(fetch_addr == RST_PC, "R1", "reset fetch_addr", fetch_addr, RST_PC);
    check(iss_valid == 1'b0, "R1", "reset iss_valid", iss_valid, 0);
    m_pc = RST_PC;
    while (!rst_n) @(negedge clk);
    while (!done) begin
      cycles++;
      if (q_word.size() == 0) expand();
      if (prev_stall) begin
        check(iss_valid == 1'b1, "R8", "valid held", iss_valid, 1);
        check(iss_word == prev_word && iss_bubble == prev_bub, "R8", "word held",
              iss_word, prev_word);
      end
      if (q_nf[0]) begin
        check(fetch_addr == q_addr[0], q_tag[0], "fetch_addr", fetch_addr, q_addr[0]);
        if (!fetch_valid) check(iss_valid == 1'b0, "R10", "valid without word", iss_valid, 0);
      end else begin
        check(iss_valid == 1'b1, "R5", "bubble offered", iss_valid, 1);
        check(fetch_ready == 1'b0, "R5", "bubble consumes no word", fetch_ready, 0);
      end
      if (iss_valid && iss_ready) begin
        check(iss_word == q_word[0], q_tag[0], "iss_word", iss_word, q_word[0]);
        check(iss_bubble == q_bub[0], q_bub[0] ? "R9" : q_tag[0], "iss_bubble",
              iss_bubble, q_bub[0]);
        void'(q_word.pop_front()); void'(q_bub.pop_front()); void'(q_nf.pop_front());
        void'(q_addr.pop_front()); void'(q_tag.pop_front());
        fires++;
      end
      fetched    = fetch_valid && fetch_ready;
      prev_stall = iss_valid && !iss_ready;
      prev_word  = iss_word;
      prev_bub   = iss_bubble;
      if (fires >= 3000) done = 1;
      else if (cycles >= 50000) begin
        check(1'b0, "R10", "watchdog expired", fires, 3000);
        done = 1;
      end
      else @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule